// File: doc/BRIEF.md
# Non-Destructive Burst Memory Self-Test

This block tests a single-port synchronous RAM while the RAM stays in functional use. It sits between the functional logic and the memory port, and it divides the test into short bursts. Each burst covers a small window of consecutive words. A burst is launched only in a cycle where self-test is enabled and the functional side is not requesting the memory. Once a burst is running, it owns the port until it finishes.

For every word in its window, a burst takes six memory operations in a fixed order:

1. Read the original contents into a save register.
2. Write a test pattern.
3. Read back and compare.
4. Write the inverted pattern.
5. Read back and compare.
6. Write the saved contents back.

Because of the final write, functional data survives every burst, including a burst that finds a fault. A persistent word pointer carries over from one burst to the next. Coverage of the whole array therefore builds up over many bursts. The window size is derived from the maximum burst length: six cycles per word. When the burst that holds the top address completes, the block pulses `done` and the pointer wraps to zero. A burst that reaches the top address ends there, even if its window is not full.

The memory is assumed to return read data one cycle after a read is accepted. The functional side sees the same latency through `fn_rdata`.

Top module: `burst_memtest`

## Requirements
- R1: A burst starts only after a cycle in which `test_en` is 1, `fn_req` is 0 and no burst is running. When no burst is running, a functional request is granted in the same cycle (`fn_gnt` = 1) and drives the memory port.
- R2: A burst keeps `busy` high for exactly 6*WIN consecutive cycles, where WIN = MAX_BURST/6. With MAX_BURST = 24 this is 24 cycles covering 4 words.
- R3: Per word, the memory operations occur in this order: read, write pattern, read, write inverted pattern, read, write original. The pattern for an even address has bit i set when i is even (0x5555 for 16 bits). An odd address uses the complement (0xAAAA).
- R4: Successive bursts cover successive windows. The first burst after reset starts at address 0, and each following burst starts WIN words above the previous one.
- R5: After any burst, every memory word holds the value it held before the burst. This also holds when a fault was detected.
- R6: A functional request raised while a burst runs sees `fn_gnt` = 0 until the burst's final restore write is done. It is then served with correct data, after a stall of at most MAX_BURST cycles.
- R7: A compare mismatch sets `fail`, and `fail_addr` captures the address of the first failing word. Both hold their values until reset.
- R8: `done` is a one-cycle pulse. It is raised in the cycle after the burst containing the top address ends, and the next burst then starts again at address 0.
- R9: After reset, `busy`, `done` and `fail` are 0 and `fail_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| test_en | input | 1 | Allows bursts to be launched in idle cycles |
| fn_req | input | 1 | Functional memory request |
| fn_we | input | 1 | Functional write (1) or read (0) |
| fn_addr | input | ADDR_W | Functional word address |
| fn_wdata | input | DATA_W | Functional write data |
| fn_gnt | output | 1 | Functional request accepted this cycle |
| fn_rdata | output | DATA_W | Read data, valid one cycle after a granted read |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one-cycle latency |
| busy | output | 1 | A burst owns the memory port |
| done | output | 1 | Pulse: the last window of a full pass finished |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ADDR_W | Address of the first failing word |

## Verification
The bench builds the block with ADDR_W = 4, DATA_W = 16 and the default MAX_BURST of 24. That gives 4-word windows and four bursts per pass. Pointer wraparound, the `done` pulse and several complete passes all fit within a few hundred cycles. At this size, a functional read raised in the first cycle of a burst shows the full worst-case stall. A stuck bit injected in the bench's memory model at an odd address exercises fault capture, and the same injection shows that the restore write still returns the original data.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

  typedef enum logic [2:0] {
    PH_SAVE    = 3'd0,
    PH_WPAT    = 3'd1,
    PH_RPAT    = 3'd2,
    PH_WINV    = 3'd3,
    PH_RINV    = 3'd4,
    PH_RESTORE = 3'd5
  } phase_e;

  localparam int unsigned OPS_PER_WORD = 6;

endpackage

// File: rtl/mbt_sequencer.sv
module mbt_sequencer
  import mbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WIN    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  output logic              active,
  output phase_e            phase,
  output logic [ADDR_W-1:0] word_addr,
  output logic              pass_done
);

  localparam int unsigned CNT_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN - 1);

  logic              active_q, active_d;
  phase_e            phase_q, phase_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0]  wcnt_q, wcnt_d;
  logic              done_q, done_d;

  logic word_end, at_top, burst_end;

  assign word_end  = active_q && (phase_q == PH_RESTORE);
  assign at_top    = &ptr_q;
  assign burst_end = word_end && ((wcnt_q == CNT_LAST) || at_top);

  always_comb begin
    active_d = active_q;
    phase_d  = phase_q;
    ptr_d    = ptr_q;
    wcnt_d   = wcnt_q;
    done_d   = 1'b0;
    if (!active_q) begin
      if (launch) begin
        active_d = 1'b1;
        phase_d  = PH_SAVE;
        wcnt_d   = '0;
      end
    end else if (word_end) begin
      ptr_d   = ptr_q + 1'b1;
      wcnt_d  = wcnt_q + 1'b1;
      phase_d = PH_SAVE;
      if (burst_end) begin
        active_d = 1'b0;
        done_d   = at_top;
      end
    end else begin
      phase_d = phase_e'(phase_q + 3'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= PH_SAVE;
      ptr_q    <= '0;
      wcnt_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      phase_q  <= phase_d;
      ptr_q    <= ptr_d;
      wcnt_q   <= wcnt_d;
      done_q   <= done_d;
    end
  end

  assign active    = active_q;
  assign phase     = phase_q;
  assign word_addr = ptr_q;
  assign pass_done = done_q;

endmodule

// File: rtl/mbt_datapath.sv
module mbt_datapath
  import mbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  phase_e            phase,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] bist_wdata,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);

  logic [DATA_W-1:0] pat;

  // Checkerboard background whose phase follows the word address.
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_pat
      assign pat[i] = ((i % 2) == 0) ^ word_addr[0];
    end
  endgenerate

  logic              cap_save_q, cap_save_d;
  logic [DATA_W-1:0] save_q;
  logic              cmp_vld_q, cmp_vld_d;
  logic [DATA_W-1:0] cmp_exp_q, cmp_exp_d;
  logic [ADDR_W-1:0] cmp_addr_q;
  logic              fail_q, fail_d;
  logic [ADDR_W-1:0] fail_addr_q, fail_addr_d;
  logic              mismatch;

  assign cap_save_d = active && (phase == PH_SAVE);
  assign cmp_vld_d  = active && ((phase == PH_RPAT) || (phase == PH_RINV));
  assign cmp_exp_d  = (phase == PH_RPAT) ? pat : ~pat;
  assign mismatch   = cmp_vld_q && (mem_rdata != cmp_exp_q);

  always_comb begin
    fail_d      = fail_q;
    fail_addr_d = fail_addr_q;
    if (mismatch && !fail_q) begin
      fail_d      = 1'b1;
      fail_addr_d = cmp_addr_q;
    end
  end

  always_comb begin
    case (phase)
      PH_WPAT: bist_wdata = pat;
      PH_WINV: bist_wdata = ~pat;
      default: bist_wdata = save_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_save_q  <= 1'b0;
      cmp_vld_q   <= 1'b0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      cap_save_q  <= cap_save_d;
      cmp_vld_q   <= cmp_vld_d;
      fail_q      <= fail_d;
      fail_addr_q <= fail_addr_d;
    end
  end

  // Data-only registers, loaded under explicit enables.
  always_ff @(posedge clk) begin
    if (cap_save_q) save_q <= mem_rdata;
    if (cmp_vld_d) begin
      cmp_exp_q  <= cmp_exp_d;
      cmp_addr_q <= word_addr;
    end
  end

  assign fail      = fail_q;
  assign fail_addr = fail_addr_q;

endmodule

// File: rtl/mbt_arbiter.sv
module mbt_arbiter
  import mbt_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              test_en,
  input  logic              fn_req,
  input  logic              fn_we,
  input  logic [ADDR_W-1:0] fn_addr,
  input  logic [DATA_W-1:0] fn_wdata,
  input  logic              bist_active,
  input  phase_e            phase,
  input  logic [ADDR_W-1:0] bist_addr,
  input  logic [DATA_W-1:0] bist_wdata,
  output logic              fn_gnt,
  output logic              launch,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  logic bist_we;

  assign bist_we = (phase == PH_WPAT) || (phase == PH_WINV) || (phase == PH_RESTORE);
  assign fn_gnt  = fn_req && !bist_active;
  assign launch  = test_en && !fn_req && !bist_active;

  always_comb begin
    if (bist_active) begin
      mem_en    = 1'b1;
      mem_we    = bist_we;
      mem_addr  = bist_addr;
      mem_wdata = bist_wdata;
    end else begin
      mem_en    = fn_req;
      mem_we    = fn_req && fn_we;
      mem_addr  = fn_addr;
      mem_wdata = fn_wdata;
    end
  end

endmodule

// File: rtl/burst_memtest.sv
module burst_memtest
  import mbt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MAX_BURST = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  input  logic              fn_req,
  input  logic              fn_we,
  input  logic [ADDR_W-1:0] fn_addr,
  input  logic [DATA_W-1:0] fn_wdata,
  output logic              fn_gnt,
  output logic [DATA_W-1:0] fn_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);

  localparam int unsigned WIN_RAW = MAX_BURST / OPS_PER_WORD;
  localparam int unsigned WIN     = (WIN_RAW < 1) ? 1 : WIN_RAW;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic              launch, active;
  phase_e            phase;
  logic [ADDR_W-1:0] word_addr;
  logic [DATA_W-1:0] bist_wdata;

  mbt_sequencer #(.ADDR_W(ADDR_W), .WIN(WIN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .launch    (launch),
    .active    (active),
    .phase     (phase),
    .word_addr (word_addr),
    .pass_done (done)
  );

  mbt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .active     (active),
    .phase      (phase),
    .word_addr  (word_addr),
    .mem_rdata  (mem_rdata),
    .bist_wdata (bist_wdata),
    .fail       (fail),
    .fail_addr  (fail_addr)
  );

  mbt_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .test_en     (test_en),
    .fn_req      (fn_req),
    .fn_we       (fn_we),
    .fn_addr     (fn_addr),
    .fn_wdata    (fn_wdata),
    .bist_active (active),
    .phase       (phase),
    .bist_addr   (word_addr),
    .bist_wdata  (bist_wdata),
    .fn_gnt      (fn_gnt),
    .launch      (launch),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata)
  );

  assign busy     = active;
  assign fn_rdata = mem_rdata;

endmodule

// File: rtl/burst_memtest_props.sv
module burst_memtest_props #(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned MAX_BURST = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              test_en,
  input logic              fn_req,
  input logic              fn_gnt,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr
);

  localparam int unsigned WIN_RAW = MAX_BURST / 6;
  localparam int unsigned BURST_CYC = ((WIN_RAW < 1) ? 1 : WIN_RAW) * 6;
  localparam int unsigned CW = $clog2(BURST_CYC + MAX_BURST + 2);

  logic [CW-1:0] stall_cnt, busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_cnt <= '0;
      busy_cnt  <= '0;
    end else begin
      stall_cnt <= (fn_req && !fn_gnt) ? stall_cnt + 1'b1 : '0;
      busy_cnt  <= busy ? busy_cnt + 1'b1 : '0;
    end
  end

  a_r1_launch_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(test_en && !fn_req));

  a_r1_grant_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && fn_req) |-> fn_gnt);

  a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fn_gnt);

  a_r6_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cnt <= CW'(MAX_BURST));

  a_r2_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CW'(BURST_CYC));

  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail);

  a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> $stable(fail_addr));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));

endmodule

bind burst_memtest burst_memtest_props #(.ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST)) u_props (
  .clk       (clk),
  .rst_n     (rst_n),
  .test_en   (test_en),
  .fn_req    (fn_req),
  .fn_gnt    (fn_gnt),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .fail_addr (fail_addr)
);

// File: tb/burst_memtest_test.sv
module burst_memtest_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NWORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          test_en, fn_req, fn_we;
  logic [AW-1:0] fn_addr;
  logic [DW-1:0] fn_wdata;
  logic          fn_gnt;
  logic [DW-1:0] fn_rdata;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          busy, done, fail;
  logic [AW-1:0] fail_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  burst_memtest #(.ADDR_W(AW), .DATA_W(DW), .MAX_BURST(24)) uut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .fn_req(fn_req), .fn_we(fn_we),
    .fn_addr(fn_addr), .fn_wdata(fn_wdata), .fn_gnt(fn_gnt), .fn_rdata(fn_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr)
  );

  // Memory model with an optional stuck-at-1 on bit 0 of one word.
  logic [DW-1:0] ram [NWORDS];
  logic          stuck_on = 1'b0;
  logic [AW-1:0] stuck_addr = 4'd9;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= (stuck_on && mem_addr == stuck_addr) ? (mem_wdata | 16'h0001) : mem_wdata;
      else        mem_rdata <= ram[mem_addr];
    end
  end

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] shadow [NWORDS];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard for functional reads.
  logic [DW-1:0] exp_q[$];
  logic          rd_due = 1'b0;

  always @(posedge clk) rd_due <= fn_req && fn_gnt && !fn_we;

  always @(negedge clk) begin
    if (rd_due) begin
      if (exp_q.size() == 0) check(1'b0, "R5", "unexpected read", 32'(fn_rdata), 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(fn_rdata == e, "R5", "read data", 32'(fn_rdata), 32'(e));
      end
    end
  end

  // Burst monitors.
  int            run_len = 0;
  int            len_q[$];
  logic [AW-1:0] start_q[$];
  int            done_cnt = 0;
  int            done_wide = 0;
  logic          prev_busy = 1'b0, prev_done = 1'b0;
  logic          log_on = 1'b0;
  logic [DW+AW:0] wlog[$];

  always @(negedge clk) begin
    if (busy && !prev_busy) start_q.push_back(mem_addr);
    if (busy) run_len++;
    else if (prev_busy) begin
      len_q.push_back(run_len);
      run_len = 0;
    end
    if (done) done_cnt++;
    if (done && prev_done) done_wide++;
    prev_busy = busy;
    prev_done = done;
  end

  always @(posedge clk)
    if (log_on && busy && mem_en) wlog.push_back({mem_we, mem_addr, mem_we ? mem_wdata : 16'h0});

  function automatic logic [DW-1:0] pat_of(input logic [AW-1:0] a);
    return a[0] ? 16'hAAAA : 16'h5555;
  endfunction

  task automatic fn_xfer(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, output int stall);
    fn_req = 1'b1; fn_we = we; fn_addr = a; fn_wdata = d; stall = 0;
    #1;
    while (!fn_gnt) begin
      @(negedge clk); #1; stall++;
    end
    if (we) shadow[a] = d;
    else    exp_q.push_back(shadow[a]);
    @(negedge clk);
    fn_req = 1'b0;
  endtask

  task automatic read_all();
    int s;
    for (int a = 0; a < NWORDS; a++) fn_xfer(1'b0, AW'(a), '0, s);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int s;
    int bad;
    rst_n = 1'b0; test_en = 1'b0; fn_req = 1'b0; fn_we = 1'b0; fn_addr = '0; fn_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    check(busy == 1'b0, "R9", "busy", 32'(busy), 0);
    check(done == 1'b0, "R9", "done", 32'(done), 0);
    check(fail == 1'b0, "R9", "fail", 32'(fail), 0);
    check(fail_addr == '0, "R9", "fail_addr", 32'(fail_addr), 0);

    // Preload with self-test disabled; R1: no burst may start.
    for (int a = 0; a < NWORDS; a++) fn_xfer(1'b1, AW'(a), 16'hB2C1 ^ (16'(a) * 16'h0222), s);
    repeat (10) @(negedge clk);
    check(start_q.size() == 0, "R1", "burst without test_en", 32'(start_q.size()), 0);

    // R1: enabled but functional side keeps requesting -> no burst, granted.
    test_en = 1'b1;
    fn_req = 1'b1; fn_we = 1'b1; fn_addr = 4'd3; fn_wdata = shadow[3];
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      #1; if (!fn_gnt) bad++;
      @(negedge clk);
    end
    fn_req = 1'b0;
    check(bad == 0, "R1", "grant while idle", 32'(bad), 0);
    check(start_q.size() == 0, "R1", "burst while requested", 32'(start_q.size()), 0);

    // First full pass.
    log_on = 1'b1;
    wait (len_q.size() == 1);
    log_on = 1'b0;
    wait (done_cnt == 1);
    test_en = 1'b0;
    @(negedge clk);

    check(start_q.size() == 4, "R4", "burst count", 32'(start_q.size()), 4);
    for (int k = 0; k < 4 && k < start_q.size(); k++)
      check(start_q[k] == AW'(4 * k), "R4", "window start", 32'(start_q[k]), 32'(4 * k));
    bad = 0;
    foreach (len_q[k]) if (len_q[k] != 24) bad++;
    check(bad == 0, "R2", "burst length not 24", 32'(bad), 0);

    // R3 operation order for the first burst (words 0..3).
    check(wlog.size() == 24, "R3", "ops in burst", 32'(wlog.size()), 24);
    bad = 0;
    for (int a = 0; a < 4; a++) begin
      logic [DW+AW:0] ex [6];
      ex[0] = {1'b0, AW'(a), 16'h0};
      ex[1] = {1'b1, AW'(a), pat_of(AW'(a))};
      ex[2] = {1'b0, AW'(a), 16'h0};
      ex[3] = {1'b1, AW'(a), ~pat_of(AW'(a))};
      ex[4] = {1'b0, AW'(a), 16'h0};
      ex[5] = {1'b1, AW'(a), shadow[a]};
      for (int j = 0; j < 6; j++)
        if (wlog.size() > a * 6 + j && wlog[a * 6 + j] != ex[j]) bad++;
    end
    check(bad == 0, "R3", "op sequence mismatches", 32'(bad), 0);
    check(done_wide == 0, "R8", "done wider than one cycle", 32'(done_wide), 0);
    check(fail == 1'b0, "R7", "fail without fault", 32'(fail), 0);

    // R5 contents preserved.
    read_all();

    // R8 wrap and R6 stall: raise a read in the first cycle of a burst.
    test_en = 1'b1;
    wait (start_q.size() == 5);
    check(start_q[4] == '0, "R8", "wrap to zero", 32'(start_q[4]), 0);
    fn_xfer(1'b0, 4'd2, '0, s);
    check(s == 24, "R6", "stall cycles", 32'(s), 24);
    wait (done_cnt == 2);
    test_en = 1'b0;
    @(negedge clk);
    read_all();

    // R7 fault at address 9, restore still performed (R5).
    stuck_on = 1'b1;
    test_en = 1'b1;
    wait (done_cnt == 3);
    test_en = 1'b0;
    @(negedge clk);
    check(fail == 1'b1, "R7", "fail set", 32'(fail), 1);
    check(fail_addr == 4'd9, "R7", "fail_addr", 32'(fail_addr), 9);
    read_all();

    // R7 sticky after a clean pass.
    stuck_on = 1'b0;
    test_en = 1'b1;
    wait (done_cnt == 4);
    test_en = 1'b0;
    @(negedge clk);
    check(fail == 1'b1, "R7", "fail sticky", 32'(fail), 1);
    check(fail_addr == 4'd9, "R7", "fail_addr held", 32'(fail_addr), 9);
    check(done_wide == 0, "R8", "done pulse width", 32'(done_wide), 0);
    read_all();
    check(exp_q.size() == 0, "R5", "pending reads", 32'(exp_q.size()), 0);

    finish_run();
  end

endmodule